// File: doc/BRIEF.md
# ADC Serial Command Port

This block is the digital host side of a serial data converter. A host opens a 16-bit transfer either by pulling the chip select low (select framing) or by dropping a frame-sync line while the chip is selected (frame-sync framing). During the transfer the block shifts a command word in on SDI, most significant bit first, and shifts a 16-bit result word out on SDO with a separate output enable for an external tri-state driver. The two framing styles use opposite serial-clock edges: select framing captures on rising SCLK and launches on falling SCLK, and frame-sync framing does the reverse.

Every pin is brought into a fast system clock through a synchronizer, and serial clock edges are found by comparing consecutive synchronized samples. The top four bits of a complete word form a command code. The lower twelve bits are its payload. One command code writes the payload into a configuration register. One bit of that register makes the status pin either track the converter's busy flag or act as a latched interrupt. A plain result-word input and a busy input take the place of the conversion engine.

Top module: `adc_cmd_port`

## Requirements
- R1: While reset is held and right after it, sdo_oe is 0, cmd_valid is 0, cfg_word is 0 and irq_n is 1.
- R2: In select framing (cs_n falls while fs is high), SDI is captured on rising SCLK, MSB first. On the 16th capture, cmd_valid pulses for one cycle with cmd_code equal to bits 15..12 and cmd_payload equal to bits 11..0.
- R3: A falling cs_n turns sdo_oe on and presents result_word bit 15 before the first capture edge. Each launch edge (the edge opposite the capture edge) presents the next lower bit. After 16 bits SDO carries zeros. sdo_oe returns to 0 once cs_n is high.
- R4: A falling fs while cs_n is low restarts the frame in frame-sync framing. It captures on falling SCLK and launches on rising SCLK, and it turns sdo_oe off at the launch edge after the 16th bit, while cs_n is still low.
- R5: Capture stops after 16 edges. Further SCLK edges in the same frame produce no second cmd_valid and do not alter the delivered word.
- R6: A frame closed by cs_n rising before 16 captures produces no cmd_valid and leaves cfg_word unchanged.
- R7: If fs is low when cs_n falls, SDI is not captured in that frame. No cmd_valid follows.
- R8: A complete word whose code is 4'hA loads its payload into cfg_word in the same cycle as cmd_valid. Any other code leaves cfg_word unchanged.
- R9: When cfg_word bit 0 is 0 (status mode), irq_n equals the inverse of conv_busy one cycle later.
- R10: When cfg_word bit 0 is 1 (interrupt mode), a falling conv_busy drives irq_n low. irq_n stays low until the next cs_n fall or fs rise.
- R11: In interrupt mode, the cycle irq_n falls also turns sdo_oe off even with cs_n low. SDO stays disabled until the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCLK |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| fs | input | 1 | Frame sync, falling edge starts a frame-sync transfer |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial command data in |
| result_word | input | WORD_W | Word to send, loaded at frame start |
| conv_busy | input | 1 | Converter busy flag, synchronous to clk |
| sdo | output | 1 | Serial result data out |
| sdo_oe | output | 1 | Output enable for the SDO driver |
| cmd_valid | output | 1 | One-cycle strobe for a complete command |
| cmd_code | output | CODE_W | Decoded command code |
| cmd_payload | output | WORD_W-CODE_W | Trailing payload bits |
| cfg_word | output | WORD_W-CODE_W | Configuration register |
| irq_n | output | 1 | Status or interrupt pin, active low |

## Verification
A wrong edge-counter value shows as a missing or early cmd_valid strobe, or as a strobe carrying a shifted code, within one SCLK period of the 16th edge. A framing-mode register holding the wrong state shows on SDO as bits that change on the capture edge, so the host samples the wrong bit at the next edge. A stuck interrupt flag or enable register shows within a few system clocks as irq_n failing to clear or SDO staying driven after an interrupt.

// File: rtl/acp_pkg.sv
package acp_pkg;
  typedef enum logic {
    FRM_SEL = 1'b0,
    FRM_SYNC = 1'b1
  } frame_mode_e;
endpackage

// File: rtl/acp_sync.sv
module acp_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/acp_framer.sv
module acp_framer
  import acp_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cs_s,
  input  logic        fs_s,
  input  logic        sclk_s,
  output logic        frame_start,
  output logic        rx_arm,
  output logic        cs_fall,
  output logic        cs_rise,
  output logic        fs_rise,
  output logic        cap_edge,
  output logic        lau_edge,
  output frame_mode_e mode
);
  logic cs_q, fs_q, sclk_q;
  logic fs_fall, sclk_rise, sclk_fall, sync_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q   <= 1'b1;
      fs_q   <= 1'b1;
      sclk_q <= 1'b1;
      mode   <= FRM_SEL;
    end else begin
      cs_q   <= cs_s;
      fs_q   <= fs_s;
      sclk_q <= sclk_s;
      if (sync_start)   mode <= FRM_SYNC;
      else if (cs_fall) mode <= FRM_SEL;
    end
  end

  always_comb begin
    cs_fall     = cs_q & ~cs_s;
    cs_rise     = ~cs_q & cs_s;
    fs_fall     = fs_q & ~fs_s;
    fs_rise     = ~fs_q & fs_s;
    sclk_rise   = ~sclk_q & sclk_s;
    sclk_fall   = sclk_q & ~sclk_s;
    sync_start  = fs_fall & ~cs_s;
    frame_start = cs_fall | sync_start;
    rx_arm      = (cs_fall & fs_s) | sync_start;
    cap_edge    = (mode == FRM_SYNC) ? sclk_fall : sclk_rise;
    lau_edge    = (mode == FRM_SYNC) ? sclk_rise : sclk_fall;
  end
endmodule

// File: rtl/acp_rx.sv
module acp_rx #(
  parameter int WORD_W = 16,
  parameter int CODE_W = 4,
  parameter logic [CODE_W-1:0] CFG_WR_CODE = 'hA
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     frame_start,
  input  logic                     rx_arm,
  input  logic                     cs_rise,
  input  logic                     cap_edge,
  input  logic                     sdi_s,
  output logic                     cmd_valid,
  output logic [CODE_W-1:0]        cmd_code,
  output logic [WORD_W-CODE_W-1:0] cmd_payload,
  output logic [WORD_W-CODE_W-1:0] cfg_word
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic              rx_en;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] shreg, word_next;

  assign word_next = {shreg[WORD_W-2:0], sdi_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_en       <= 1'b0;
      cnt         <= '0;
      shreg       <= '0;
      cmd_valid   <= 1'b0;
      cmd_code    <= '0;
      cmd_payload <= '0;
      cfg_word    <= '0;
    end else begin
      cmd_valid <= 1'b0;
      if (frame_start) begin
        rx_en <= rx_arm;
        cnt   <= '0;
      end else if (cs_rise) begin
        rx_en <= 1'b0;
      end else if (cap_edge && rx_en) begin
        shreg <= word_next;
        cnt   <= cnt + 1'b1;
        if (cnt == LAST) begin
          rx_en       <= 1'b0;
          cmd_valid   <= 1'b1;
          cmd_code    <= word_next[WORD_W-1 -: CODE_W];
          cmd_payload <= word_next[WORD_W-CODE_W-1:0];
          if (word_next[WORD_W-1 -: CODE_W] == CFG_WR_CODE)
            cfg_word <= word_next[WORD_W-CODE_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/acp_tx.sv
module acp_tx
  import acp_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              cs_rise,
  input  logic              kill,
  input  logic              lau_edge,
  input  frame_mode_e       mode,
  input  logic [WORD_W-1:0] result_word,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  lcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg  <= '0;
      lcnt   <= '0;
      sdo_oe <= 1'b0;
    end else if (frame_start) begin
      shreg  <= result_word;
      lcnt   <= '0;
      sdo_oe <= 1'b1;
    end else if (cs_rise || kill) begin
      sdo_oe <= 1'b0;
    end else if (lau_edge && sdo_oe) begin
      shreg <= {shreg[WORD_W-2:0], 1'b0};
      if (lcnt != LAST) lcnt <= lcnt + 1'b1;
      if (mode == FRM_SYNC && lcnt == LAST) sdo_oe <= 1'b0;
    end
  end

  assign sdo = shreg[WORD_W-1];
endmodule

// File: rtl/acp_irq.sv
module acp_irq (
  input  logic clk,
  input  logic rst,
  input  logic int_mode,
  input  logic conv_busy,
  input  logic cs_fall,
  input  logic fs_rise,
  output logic irq_n,
  output logic kill
);
  logic busy_q, pend, pend_next;

  always_comb begin
    kill      = int_mode & busy_q & ~conv_busy;
    pend_next = pend;
    if (!int_mode)              pend_next = 1'b0;
    else if (kill)              pend_next = 1'b1;
    else if (cs_fall | fs_rise) pend_next = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      pend   <= 1'b0;
      irq_n  <= 1'b1;
    end else begin
      busy_q <= conv_busy;
      pend   <= pend_next;
      irq_n  <= int_mode ? ~pend_next : ~conv_busy;
    end
  end
endmodule

// File: rtl/adc_cmd_port.sv
module adc_cmd_port
  import acp_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CODE_W = 4,
  parameter int SYNC_STAGES = 2,
  parameter logic [CODE_W-1:0] CFG_WR_CODE = 'hA,
  parameter int INT_SEL_BIT = 0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cs_n,
  input  logic                     fs,
  input  logic                     sclk,
  input  logic                     sdi,
  input  logic [WORD_W-1:0]        result_word,
  input  logic                     conv_busy,
  output logic                     sdo,
  output logic                     sdo_oe,
  output logic                     cmd_valid,
  output logic [CODE_W-1:0]        cmd_code,
  output logic [WORD_W-CODE_W-1:0] cmd_payload,
  output logic [WORD_W-CODE_W-1:0] cfg_word,
  output logic                     irq_n
);
  logic [3:0]  pins_s;
  logic        frame_start, rx_arm, cs_fall, cs_rise, fs_rise;
  logic        cap_edge, lau_edge, kill;
  frame_mode_e mode;

  acp_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1110)) u_sync (
    .clk(clk), .rst(rst), .din({cs_n, fs, sclk, sdi}), .dout(pins_s)
  );

  acp_framer u_framer (
    .clk(clk), .rst(rst), .cs_s(pins_s[3]), .fs_s(pins_s[2]), .sclk_s(pins_s[1]),
    .frame_start(frame_start), .rx_arm(rx_arm), .cs_fall(cs_fall),
    .cs_rise(cs_rise), .fs_rise(fs_rise), .cap_edge(cap_edge),
    .lau_edge(lau_edge), .mode(mode)
  );

  acp_rx #(.WORD_W(WORD_W), .CODE_W(CODE_W), .CFG_WR_CODE(CFG_WR_CODE)) u_rx (
    .clk(clk), .rst(rst), .frame_start(frame_start), .rx_arm(rx_arm),
    .cs_rise(cs_rise), .cap_edge(cap_edge), .sdi_s(pins_s[0]),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_payload(cmd_payload),
    .cfg_word(cfg_word)
  );

  acp_tx #(.WORD_W(WORD_W)) u_tx (
    .clk(clk), .rst(rst), .frame_start(frame_start), .cs_rise(cs_rise),
    .kill(kill), .lau_edge(lau_edge), .mode(mode), .result_word(result_word),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );

  acp_irq u_irq (
    .clk(clk), .rst(rst), .int_mode(cfg_word[INT_SEL_BIT]), .conv_busy(conv_busy),
    .cs_fall(cs_fall), .fs_rise(fs_rise), .irq_n(irq_n), .kill(kill)
  );
endmodule

// File: rtl/adc_cmd_port_chk.sv
module adc_cmd_port_chk #(
  parameter int WORD_W = 16,
  parameter int CODE_W = 4,
  parameter logic [CODE_W-1:0] CFG_WR_CODE = 'hA,
  parameter int INT_SEL_BIT = 0
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     cs_n,
  input logic                     conv_busy,
  input logic                     sdo_oe,
  input logic                     cmd_valid,
  input logic [CODE_W-1:0]        cmd_code,
  input logic [WORD_W-CODE_W-1:0] cfg_word,
  input logic                     irq_n
);
  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);

  assert_oe_off_deselected_R3: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !sdo_oe);

  assert_cfg_only_by_write_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_word) |-> (cmd_valid && cmd_code == CFG_WR_CODE));

  assert_status_follows_busy_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg_word[INT_SEL_BIT]) |-> (irq_n == !$past(conv_busy)));

  assert_irq_kills_sdo_R11: assert property (@(posedge clk) disable iff (rst)
    ($fell(irq_n) && $past(cfg_word[INT_SEL_BIT])) |-> !sdo_oe);
endmodule

bind adc_cmd_port adc_cmd_port_chk #(
  .WORD_W(WORD_W), .CODE_W(CODE_W), .CFG_WR_CODE(CFG_WR_CODE), .INT_SEL_BIT(INT_SEL_BIT)
) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .conv_busy(conv_busy), .sdo_oe(sdo_oe),
  .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cfg_word(cfg_word), .irq_n(irq_n)
);

// File: tb/adc_cmd_port_bench.sv
module adc_cmd_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HP = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1, fs = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [15:0] result_word = '0;
  logic        conv_busy = 1'b0;
  logic        sdo, sdo_oe, cmd_valid, irq_n;
  logic [3:0]  cmd_code;
  logic [11:0] cmd_payload, cfg_word;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [15:0] exp_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  adc_cmd_port u_adc_cmd_port (
    .clk(clk), .rst(rst), .cs_n(cs_n), .fs(fs), .sclk(sclk), .sdi(sdi),
    .result_word(result_word), .conv_busy(conv_busy), .sdo(sdo), .sdo_oe(sdo_oe),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_payload(cmd_payload),
    .cfg_word(cfg_word), .irq_n(irq_n)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on each command strobe (R2)
  always @(negedge clk) begin
    if (!rst && cmd_valid) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected strobe", {cmd_code, cmd_payload}, 32'hDEAD);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check("R2 command word", {cmd_code, cmd_payload}, e);
      end
    end
  end

  // Select-framing transfer; extra bits beyond 16 are driven as ones
  task automatic sel_frame(input logic [15:0] word, input int nbits,
                           input logic [15:0] res, input logic fs_lvl,
                           input bit expect_cmd, input bit chk_sdo);
    result_word = res;
    fs = fs_lvl;
    if (expect_cmd) exp_q.push_back(word);
    tick(HP);
    cs_n = 1'b0;
    tick(HP);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 16) ? word[15-i] : 1'b1;
      tick(HP);
      if (chk_sdo) begin
        check("R3 sdo enabled", sdo_oe, 1);
        check("R3 sdo bit", sdo, (i < 16) ? res[15-i] : 1'b0);
      end
      sclk = 1'b1;
      tick(HP);
      sclk = 1'b0;
      tick(HP);
    end
    cs_n = 1'b1;
    fs = 1'b1;
    tick(HP);
    check("R3 sdo off after deselect", sdo_oe, 0);
    check("R2 scoreboard drained", exp_q.size(), 0);
  endtask

  // Frame-sync transfer of exactly 16 bits
  task automatic sync_frame(input logic [15:0] word, input logic [15:0] res);
    result_word = res;
    exp_q.push_back(word);
    sclk = 1'b1;
    fs = 1'b1;
    tick(HP);
    cs_n = 1'b0;
    tick(HP);
    fs = 1'b0;
    tick(HP);
    for (int i = 0; i < 16; i++) begin
      sdi = word[15-i];
      tick(HP);
      check("R4 sdo enabled", sdo_oe, 1);
      check("R4 sdo bit", sdo, res[15-i]);
      sclk = 1'b0;
      tick(HP);
      sclk = 1'b1;
      tick(HP);
    end
    check("R4 sdo off after 16th bit, select low", sdo_oe, 0);
    check("R4 select still low", cs_n, 0);
    fs = 1'b1;
    tick(HP);
    cs_n = 1'b1;
    sclk = 1'b0;
    tick(HP);
    check("R4 scoreboard drained", exp_q.size(), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(4);
    check("R1 oe in reset", sdo_oe, 0);
    rst = 1'b0;
    tick(2);
    check("R1 oe", sdo_oe, 0);
    check("R1 valid", cmd_valid, 0);
    check("R1 cfg", cfg_word, 0);
    check("R1 irq_n", irq_n, 1);

    // R2, R3, R8: normal select frames with non-config codes
    sel_frame(16'h3FFF, 16, 16'hA5C3, 1'b1, 1, 1);
    check("R8 other code keeps cfg", cfg_word, 0);
    sel_frame(16'h5A5A, 16, 16'h1234, 1'b1, 1, 1);

    // R4: frame-sync framing
    sync_frame(16'h7C0F, 16'hF00D);

    // R6: short frame with config code is dropped
    sel_frame(16'hA0FF, 8, 16'h0000, 1'b1, 0, 1);
    check("R6 short frame keeps cfg", cfg_word, 0);

    // R7: fs low at select fall disables capture
    sel_frame(16'hAFFF, 16, 16'h0000, 1'b0, 0, 0);
    check("R7 no capture keeps cfg", cfg_word, 0);

    // R5: extra edges after 16 ignored, sdo shifts zeros (R3)
    sel_frame(16'h9ABC, 20, 16'hC3C3, 1'b1, 1, 1);

    // R9: status mode tracks busy
    conv_busy = 1'b1;
    tick(2);
    check("R9 status low while busy", irq_n, 0);
    conv_busy = 1'b0;
    tick(2);
    check("R9 status high when idle", irq_n, 1);

    // R8: config write selects interrupt mode
    sel_frame(16'hA801, 16, 16'h0F0F, 1'b1, 1, 1);
    check("R8 cfg loaded", cfg_word, 12'h801);

    // R10: interrupt latch and clear by fs rise
    conv_busy = 1'b1;
    tick(3);
    check("R10 irq ignores busy high", irq_n, 1);
    conv_busy = 1'b0;
    tick(3);
    check("R10 irq set on busy fall", irq_n, 0);
    tick(10);
    check("R10 irq held", irq_n, 0);
    fs = 1'b0;
    tick(HP);
    fs = 1'b1;
    tick(HP);
    check("R10 irq cleared by fs rise", irq_n, 1);

    // R10: clear by select fall, then R11 mid-frame kill
    conv_busy = 1'b1;
    tick(2);
    conv_busy = 1'b0;
    tick(3);
    check("R10 irq set again", irq_n, 0);
    result_word = 16'hFFFF;
    cs_n = 1'b0;
    tick(HP);
    check("R10 irq cleared by select fall", irq_n, 1);
    check("R11 sdo enabled at frame start", sdo_oe, 1);
    for (int i = 0; i < 4; i++) begin
      sdi = 1'b0;
      tick(HP);
      sclk = 1'b1;
      tick(HP);
      sclk = 1'b0;
      tick(HP);
    end
    conv_busy = 1'b1;
    tick(2);
    conv_busy = 1'b0;
    tick(3);
    check("R11 irq asserted mid-frame", irq_n, 0);
    check("R11 sdo forced off, select low", sdo_oe, 0);
    for (int i = 0; i < 4; i++) begin
      tick(HP);
      sclk = 1'b1;
      tick(HP);
      sclk = 1'b0;
      tick(HP);
    end
    check("R11 sdo stays off", sdo_oe, 0);
    cs_n = 1'b1;
    tick(HP);

    // R11: next frame drives sdo again
    sel_frame(16'h2468, 16, 16'h8421, 1'b1, 1, 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule